// File: doc/BRIEF.md
# Linear PE Network with Responder Bypass

This block is the neighbour-to-neighbour communication fabric of a one-dimensional array of processing elements. Each PE owns a small data switch. The switch picks the value the PE puts on the network: its own register operand, the broadcast word from the control unit, the immediate word from the control unit, or zero. It also captures the word that arrives from the left or the right neighbour into a per-PE receive register, which feeds the PE's execute stage.

Each PE's mask bit decides whether it takes part. A PE with its mask bit set is a responder and stays connected. A PE with its mask bit clear switches into bypass: it passes neighbour traffic straight through a combinational path and drops out of the chain. A shift therefore moves data one logical step between consecutive responders, however many bypassed PEs lie between them. The transfer finishes in a single clock cycle. The two ends of the array are not joined.

Top module: `pe_link_net`

## Requirements
- R1: While `rstN` is low, and on the first clock after it rises with no shift requested, every `rxData` lane is zero and every `rxValid` bit is 0.
- R2: Each PE's 2-bit lane of `srcSel` picks what it transmits. Code 0 selects its `regData` lane, code 1 selects `bcastData`, code 2 selects `immData` and code 3 selects zero.
- R3: A shift with `shiftDir`=0 carries data toward higher indices. Each responder i loads the transmitted word of the nearest responder with a lower index and sets `rxValid[i]` to 1.
- R4: A shift with `shiftDir`=1 carries data toward lower indices. Each responder i loads the transmitted word of the nearest responder with a higher index and sets `rxValid[i]` to 1.
- R5: A PE whose `respMask` bit is 0 keeps its `rxData` and `rxValid` unchanged during a shift. Its own transmitted word reaches no other PE.
- R6: A responder with no responder on the requested side loads zero and clears its `rxValid`. Data never wraps from one end of the array to the other.
- R7: While `shiftEn` is 0, every `rxData` lane and every `rxValid` bit holds its value, whatever the other inputs do.
- R8: A shift sampled at a rising clock edge shows its result on `rxData` and `rxValid` right after that edge, in one cycle, however many PEs are bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| shiftEn | input | 1 | Do a one-step logical shift this cycle |
| shiftDir | input | 1 | 0: toward higher index, 1: toward lower index |
| respMask | input | NUM_PE | 1 marks a responder, 0 marks a bypassed PE |
| srcSel | input | 2*NUM_PE | Per-PE transmit source code, lane i at bits 2i+1:2i |
| regData | input | NUM_PE*DATA_W | Per-PE register operand, lane i at bits i*DATA_W upward |
| bcastData | input | DATA_W | Broadcast word from the control unit |
| immData | input | DATA_W | Immediate word from the control unit |
| rxData | output | NUM_PE*DATA_W | Per-PE received word, lane i at bits i*DATA_W upward |
| rxValid | output | NUM_PE | Per-PE flag: the last shift delivered a word |

## Verification
The assertions take as given that `shiftEn`, `shiftDir`, `respMask` and `srcSel` are free of X and are stable around each rising edge. They also assume that a shift's source words come from the same cycle as its mask, because the bypass chain is purely combinational. The bench changes every input only on the falling edge and holds it through the next rising edge. It covers dense, sparse, single-responder and empty masks, all four source codes and both directions. Idle cycles come with scrambled data, so any leak through a held register would show.

// File: rtl/pe_link_pkg.sv
package pe_link_pkg;

  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_BCAST = 2'd1,
    SRC_IMM   = 2'd2,
    SRC_ZERO  = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic capture;   // load receive registers of responders
    logic fromLow;   // take data from the lower-index side
  } netStrobe_t;

endpackage

// File: rtl/pe_src_mux.sv
module pe_src_mux #(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] regWord,
  input  logic [DATA_W-1:0] bcastWord,
  input  logic [DATA_W-1:0] immWord,
  output logic [DATA_W-1:0] txWord
);
  import pe_link_pkg::*;

  always_comb begin
    unique case (srcSel_e'(sel))
      SRC_REG:   txWord = regWord;
      SRC_BCAST: txWord = bcastWord;
      SRC_IMM:   txWord = immWord;
      default:   txWord = '0;
    endcase
  end
endmodule

// File: rtl/pe_link_ctrl.sv
module pe_link_ctrl (
  input  logic                    shiftEn,
  input  logic                    shiftDir,
  output pe_link_pkg::netStrobe_t strobe
);
  always_comb begin
    strobe.capture = shiftEn;
    strobe.fromLow = ~shiftDir;
  end
endmodule

// File: rtl/pe_link_datapath.sv
module pe_link_datapath #(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pe_link_pkg::netStrobe_t  strobe,
  input  logic [NUM_PE-1:0]        respMask,
  input  logic [2*NUM_PE-1:0]      srcSel,
  input  logic [NUM_PE*DATA_W-1:0] regData,
  input  logic [DATA_W-1:0]        bcastData,
  input  logic [DATA_W-1:0]        immData,
  output logic [NUM_PE*DATA_W-1:0] rxData,
  output logic [NUM_PE-1:0]        rxValid
);
  localparam int CHAIN_N = NUM_PE + 1;

  // upChain[i]: what arrives at PE i from below; dnChain[i+1]: from above
  logic              upVal [CHAIN_N];
  logic [DATA_W-1:0] upDat [CHAIN_N];
  logic              dnVal [CHAIN_N];
  logic [DATA_W-1:0] dnDat [CHAIN_N];
  logic [DATA_W-1:0] txWord [NUM_PE];

  assign upVal[0]      = 1'b0;
  assign upDat[0]      = '0;
  assign dnVal[NUM_PE] = 1'b0;
  assign dnDat[NUM_PE] = '0;

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    logic              pickVal;
    logic [DATA_W-1:0] pickDat;

    pe_src_mux #(.DATA_W(DATA_W)) u_mux (
      .sel      (srcSel[2*i +: 2]),
      .regWord  (regData[i*DATA_W +: DATA_W]),
      .bcastWord(bcastData),
      .immWord  (immData),
      .txWord   (txWord[i])
    );

    // Responders inject their word; bypassed PEs pass traffic through
    assign upVal[i+1] = respMask[i] ? 1'b1     : upVal[i];
    assign upDat[i+1] = respMask[i] ? txWord[i] : upDat[i];
    assign dnVal[i]   = respMask[i] ? 1'b1     : dnVal[i+1];
    assign dnDat[i]   = respMask[i] ? txWord[i] : dnDat[i+1];

    assign pickVal = strobe.fromLow ? upVal[i] : dnVal[i+1];
    assign pickDat = strobe.fromLow ? upDat[i] : dnDat[i+1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxData[i*DATA_W +: DATA_W] <= '0;
        rxValid[i]                 <= 1'b0;
      end else if (strobe.capture && respMask[i]) begin
        rxValid[i]                 <= pickVal;
        rxData[i*DATA_W +: DATA_W] <= pickVal ? pickDat : '0;
      end
    end

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.capture |=> ($stable(rxData[i*DATA_W +: DATA_W]) && $stable(rxValid[i])));

    assert_bypass_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capture && !respMask[i]) |=>
        ($stable(rxData[i*DATA_W +: DATA_W]) && $stable(rxValid[i])));

    assert_invalid_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
      !rxValid[i] |-> (rxData[i*DATA_W +: DATA_W] == '0));

    if (i > 0) begin : g_adjUp
      assert_adjacent_up_R3: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.capture && strobe.fromLow && respMask[i] && respMask[i-1]) |=>
          (rxValid[i] && rxData[i*DATA_W +: DATA_W] == $past(txWord[i-1])));
    end else begin : g_lowEnd
      assert_low_end_R6: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.capture && strobe.fromLow && respMask[0]) |=> !rxValid[0]);
    end

    if (i < NUM_PE - 1) begin : g_adjDn
      assert_adjacent_dn_R4: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.capture && !strobe.fromLow && respMask[i] && respMask[i+1]) |=>
          (rxValid[i] && rxData[i*DATA_W +: DATA_W] == $past(txWord[i+1])));
    end else begin : g_highEnd
      assert_high_end_R6: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.capture && !strobe.fromLow && respMask[NUM_PE-1]) |=> !rxValid[NUM_PE-1]);
    end
  end
endmodule

// File: rtl/pe_link_net.sv
module pe_link_net #(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     shiftEn,
  input  logic                     shiftDir,
  input  logic [NUM_PE-1:0]        respMask,
  input  logic [2*NUM_PE-1:0]      srcSel,
  input  logic [NUM_PE*DATA_W-1:0] regData,
  input  logic [DATA_W-1:0]        bcastData,
  input  logic [DATA_W-1:0]        immData,
  output logic [NUM_PE*DATA_W-1:0] rxData,
  output logic [NUM_PE-1:0]        rxValid
);
  pe_link_pkg::netStrobe_t strobe;

  pe_link_ctrl u_ctrl (
    .shiftEn (shiftEn),
    .shiftDir(shiftDir),
    .strobe  (strobe)
  );

  pe_link_datapath #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .respMask (respMask),
    .srcSel   (srcSel),
    .regData  (regData),
    .bcastData(bcastData),
    .immData  (immData),
    .rxData   (rxData),
    .rxValid  (rxValid)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (rxValid == '0 || rstN));
endmodule

// File: tb/pe_link_net_bench.sv
module pe_link_net_bench;
  localparam int NP = 8;
  localparam int DW = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              shiftEn = 1'b0;
  logic              shiftDir = 1'b0;
  logic [NP-1:0]     respMask = '0;
  logic [2*NP-1:0]   srcSel = '0;
  logic [NP*DW-1:0]  regData = '0;
  logic [DW-1:0]     bcastData = '0;
  logic [DW-1:0]     immData = '0;
  logic [NP*DW-1:0]  rxData;
  logic [NP-1:0]     rxValid;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] expData [NP];
  logic          expVal  [NP];

  always #10 clk = ~clk;

  pe_link_net #(.NUM_PE(NP), .DATA_W(DW)) u_pe_link_net (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .shiftDir(shiftDir),
    .respMask(respMask), .srcSel(srcSel), .regData(regData),
    .bcastData(bcastData), .immData(immData), .rxData(rxData), .rxValid(rxValid)
  );

  function automatic logic [DW-1:0] sentBy(int p);
    case (srcSel[2*p +: 2])
      2'd0:    return regData[p*DW +: DW];
      2'd1:    return bcastData;
      2'd2:    return immData;
      default: return '0;
    endcase
  endfunction

  // Behavioural model: next state from the inputs now on the pins
  task automatic modelEdge();
    logic [DW-1:0] nd [NP];
    logic          nv [NP];
    for (int i = 0; i < NP; i++) begin
      nd[i] = expData[i];
      nv[i] = expVal[i];
      if (shiftEn && respMask[i]) begin
        nd[i] = '0;
        nv[i] = 1'b0;
        if (!shiftDir) begin
          for (int j = i - 1; j >= 0; j--)
            if (respMask[j] && !nv[i]) begin nv[i] = 1'b1; nd[i] = sentBy(j); end
        end else begin
          for (int j = i + 1; j < NP; j++)
            if (respMask[j] && !nv[i]) begin nv[i] = 1'b1; nd[i] = sentBy(j); end
        end
      end
    end
    for (int i = 0; i < NP; i++) begin expData[i] = nd[i]; expVal[i] = nv[i]; end
  endtask

  task automatic compareAll(string tag);
    for (int i = 0; i < NP; i++) begin
      checks++;
      if (rxData[i*DW +: DW] !== expData[i] || rxValid[i] !== expVal[i]) begin
        failures++;
        $display("FAIL %s pe%0d: actual data=%h valid=%b expected data=%h valid=%b",
                 tag, i, rxData[i*DW +: DW], rxValid[i], expData[i], expVal[i]);
      end
    end
  endtask

  // Inputs already set on the falling edge; clock once, check on the next falling edge
  task automatic cycle(string tag);
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic fillData(int seed);
    for (int i = 0; i < NP; i++) regData[i*DW +: DW] = DW'(16'h1000 * (i + 1) + seed);
    bcastData = DW'(16'hB000 + seed);
    immData   = DW'(16'hC000 + seed);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin expData[i] = '0; expVal[i] = 1'b0; end
    @(negedge clk);
    compareAll("R1 during reset");
    @(negedge clk);
    rstN = 1'b1;
    fillData(1);
    cycle("R1 after release");

    // R3: all responders, register source, toward higher index
    respMask = '1; srcSel = '0; shiftEn = 1'b1; shiftDir = 1'b0;
    cycle("R3 dense");
    // R4: toward lower index, R8 single-cycle result
    fillData(2); shiftDir = 1'b1;
    cycle("R4 dense R8");

    // R2: each source code on a dense mask
    srcSel = 16'b11_10_01_00_11_10_01_00; fillData(3); shiftDir = 1'b0;
    cycle("R2 mixed sources");
    shiftDir = 1'b1;
    cycle("R2 mixed sources down");

    // R5: sparse mask, bypassed PEs hold, long gaps crossed in one cycle
    respMask = 8'b1000_0001; srcSel = '0; fillData(4); shiftDir = 1'b0;
    cycle("R5 R8 sparse up");
    shiftDir = 1'b1; fillData(5);
    cycle("R5 sparse down");
    respMask = 8'b0101_0100; srcSel = 16'h5555;
    cycle("R2 R5 broadcast sparse");

    // R6: single responder gets nothing either way
    respMask = 8'b0001_0000; srcSel = '0; shiftDir = 1'b0;
    cycle("R6 lone up");
    shiftDir = 1'b1;
    cycle("R6 lone down");
    respMask = '0;
    cycle("R5 empty mask");

    // R7: idle with scrambled inputs
    shiftEn = 1'b0; respMask = '1; srcSel = 16'hA5A5; fillData(77);
    cycle("R7 idle");
    shiftDir = 1'b0;
    cycle("R7 idle dir");

    // Mixed stream
    for (int n = 0; n < 300; n++) begin
      shiftEn  = ($urandom % 4) != 0;
      shiftDir = $urandom % 2;
      respMask = NP'($urandom);
      srcSel   = (2*NP)'($urandom);
      for (int i = 0; i < NP; i++) regData[i*DW +: DW] = DW'($urandom);
      bcastData = DW'($urandom);
      immData   = DW'($urandom);
      cycle(!shiftEn ? "R7 stream" : (shiftDir ? "R4 stream" : "R3 stream"));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule